// File: doc/BRIEF.md
# Address-Translation Control Register with Write Legalization

This block holds the supervisor control word that steers virtual-address translation: a 4-bit scheme selector, a 16-bit address-space identifier and a 44-bit root page-table page number, packed into one 64-bit register. Software reaches it through a plain CSR port made of an address, a write strobe, write data and read data. A write reaches the register only when the requested scheme is valid for the base architecture of the hart. The base architecture is a static input. A write that fails this test is dropped as a whole, so the identifier and page-number fields are not stored either.

Downstream translation logic reads a compact decoded scheme code, so it does not need to re-decode the raw field. A one-cycle flag shows each rejected write, which lets the surrounding logic or a bench observe that legalization took place. The architecture select may change only while reset is held.

Top module: `xlat_ctl_csr`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register clears to all zeros. After reset, reads at address 0x180 return 0, `mode_dec` is 0 (bare) and `wr_reject` is 0.
- R2: Only a write to CSR address 0x180 can change the register. A write to any other address, or a cycle with `csr_we` low, leaves it unchanged. `csr_rdata` returns 0 when `csr_addr` is not 0x180.
- R3: Bits 63..60 hold the scheme selector, bits 59..44 the address-space identifier and bits 43..0 the page number. `csr_rdata` presents the stored word combinationally in that layout.
- R4: Selector value 0x0 (bare) is accepted whatever the value of `arch_is_64`.
- R5: Selector value 0x1 (32-bit paging) is accepted only when `arch_is_64` is 0.
- R6: Selector value 0x8 (39-bit paging) is accepted only when `arch_is_64` is 1.
- R7: Any other selector value, or a selector that is valid only for the other architecture, is rejected. All 64 bits of the register keep their previous contents.
- R8: An accepted write stores all 64 bits exactly as written, and the new value is readable from the edge that performs the write onward.
- R9: `mode_dec` follows the stored selector: 0 means bare, 1 means 32-bit paging, 2 means 39-bit paging. The value 3 never appears.
- R10: `wr_reject` is high for exactly the one cycle after the edge that rejects a write to 0x180. It stays low after accepted writes and after writes to other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| arch_is_64 | input | 1 | Base architecture: 1 = 64-bit, 0 = 32-bit; changed only under reset |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, combinational |
| mode_dec | output | 2 | Decoded translation scheme of the stored word |
| wr_reject | output | 1 | One-cycle pulse after a rejected write |

## Verification
The stored word, `csr_rdata` and `mode_dec` all change at the same rising edge that samples a write, and `wr_reject` is registered at that edge too. This means every result of a write is due one edge after the inputs are presented. The bench drives each operation at a falling edge and pushes the expected read data, decoded scheme and reject flag into a queue. A monitor pops one entry shortly after each following rising edge, while the inputs of that operation are still on the port. Writes to other addresses are followed by a read at 0x180, so an unwanted change shows up on the port.

// File: rtl/xlat_pkg.sv
// Package: shared widths, encodings and the register layout for the
// address-translation control register. Assumes a 64-bit register word.
package xlat_pkg;
    localparam int XLEN   = 64;
    localparam int MODE_W = 4;
    localparam int ASID_W = 16;
    localparam int PPN_W  = XLEN - MODE_W - ASID_W;
    localparam int CSR_AW = 12;

    localparam logic [CSR_AW-1:0] XLAT_CSR_ADDR = 12'h180;

    localparam logic [MODE_W-1:0] ENC_BARE = 4'h0;
    localparam logic [MODE_W-1:0] ENC_PG32 = 4'h1;
    localparam logic [MODE_W-1:0] ENC_PG39 = 4'h8;

    typedef enum logic [1:0] {
        SCH_BARE = 2'd0,
        SCH_PG32 = 2'd1,
        SCH_PG39 = 2'd2
    } xlat_scheme_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
    } xlat_reg_t;
endpackage

// File: rtl/xlat_mode_check.sv
// Module: xlat_mode_check
// Purely combinational. It decides whether a scheme selector is valid for
// the given base architecture and maps it to a compact scheme code.
// Assumes arch_is_64 is static. An invalid selector yields legal = 0 and
// scheme = bare.
module xlat_mode_check
    import xlat_pkg::*;
(
    input  logic              arch_is_64,
    input  logic [MODE_W-1:0] mode,
    output logic              legal,
    output xlat_scheme_e      scheme
);
    // Selector validity and scheme decode.
    always_comb begin
        legal  = 1'b0;
        scheme = SCH_BARE;
        case (mode)
            ENC_BARE: legal = 1'b1;
            ENC_PG32: if (!arch_is_64) begin
                legal  = 1'b1;
                scheme = SCH_PG32;
            end
            ENC_PG39: if (arch_is_64) begin
                legal  = 1'b1;
                scheme = SCH_PG39;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xlat_csr_store.sv
// Module: xlat_csr_store
// Holds the 64-bit control word and produces the reject pulse.
// Assumes wr_en is already qualified by address, and that wr_legal comes
// from the selector check of wr_data. Synchronous active-low reset.
module xlat_csr_store
    import xlat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_legal,
    input  xlat_reg_t wr_data,
    output xlat_reg_t cur,
    output logic      reject
);
    // Commit only accepted writes. A rejected write is dropped whole.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (wr_en && wr_legal)
            cur <= wr_data;
    end

    // One-cycle flag for each rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reject <= 1'b0;
        else
            reject <= wr_en && !wr_legal;
    end

    // R8: an accepted write is stored exactly.
    assert_legal_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_legal) |=> (cur == $past(wr_data)));

    // R7: a rejected write keeps every bit.
    assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_legal) |=> $stable(cur));

    // R10: the flag is only seen after a rejected write.
    assert_reject_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $past(wr_en && !wr_legal));
endmodule

// File: rtl/xlat_ctl_csr.sv
// Module: xlat_ctl_csr (top)
// Address-translation control register on a simple CSR port. It decodes the
// address, checks the requested selector against the base architecture,
// stores only valid words and presents the decoded scheme of the stored
// word. Assumes arch_is_64 changes only while rst_n is low.
module xlat_ctl_csr
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arch_is_64,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [1:0]        mode_dec,
    output logic              wr_reject
);
    logic         sel;
    logic         hit_wr;
    xlat_reg_t    wr_word;
    xlat_reg_t    cur_word;
    logic         req_legal;
    xlat_scheme_e req_scheme;
    logic         cur_legal;
    xlat_scheme_e cur_scheme;

    // Address match and qualified write strobe.
    always_comb begin
        sel     = (csr_addr == XLAT_CSR_ADDR);
        hit_wr  = csr_we && sel;
        wr_word = xlat_reg_t'(csr_wdata);
    end

    xlat_mode_check req_chk_i (
        .arch_is_64 (arch_is_64),
        .mode       (wr_word.mode),
        .legal      (req_legal),
        .scheme     (req_scheme)
    );

    xlat_csr_store store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hit_wr),
        .wr_legal (req_legal),
        .wr_data  (wr_word),
        .cur      (cur_word),
        .reject   (wr_reject)
    );

    xlat_mode_check cur_chk_i (
        .arch_is_64 (arch_is_64),
        .mode       (cur_word.mode),
        .legal      (cur_legal),
        .scheme     (cur_scheme)
    );

    // Read mux and decoded scheme output.
    always_comb begin
        csr_rdata = sel ? XLEN'(cur_word) : '0;
        mode_dec  = cur_scheme;
    end

    // R2: no write at this address means no change.
    assert_other_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_wr |=> $stable(cur_word));

    // R9: the stored selector is always valid, so the code is never 3.
    assert_stored_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_legal && (mode_dec != 2'd3));

    // R10: an unused request scheme leaves no trace; the flag never follows an accepted write.
    assert_no_flag_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && req_legal && (req_scheme != SCH_PG32 || !arch_is_64)) |=> !wr_reject);
endmodule

// File: tb/xlat_ctl_csr_tb_top.sv
module xlat_ctl_csr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_XL = 12'h180;

    typedef struct {
        logic [63:0] rdata;
        logic [1:0]  mdec;
        logic        rej;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arch_is_64 = 1'b1;
    logic [11:0] csr_addr = A_XL;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic [1:0]  mode_dec;
    logic        wr_reject;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [63:0] model = '0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_ctl_csr dut_i (
        .clk(clk), .rst_n(rst_n), .arch_is_64(arch_is_64),
        .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .mode_dec(mode_dec), .wr_reject(wr_reject)
    );

    function automatic bit sel_ok(input bit a64, input logic [3:0] m);
        return (m == 4'h0) || (m == 4'h1 && !a64) || (m == 4'h8 && a64);
    endfunction

    function automatic logic [1:0] dec_of(input logic [3:0] m);
        return (m == 4'h1) ? 2'd1 : (m == 4'h8) ? 2'd2 : 2'd0;
    endfunction

    task automatic check(input string req, input logic [63:0] rd, input logic [1:0] md,
                         input logic rj, input exp_t e);
        n_run++;
        if (rd !== e.rdata || md !== e.mdec || rj !== e.rej) begin
            n_fail++;
            $display("FAIL %s: rdata=%h mode_dec=%0d reject=%b expected rdata=%h mode_dec=%0d reject=%b",
                     req, rd, md, rj, e.rdata, e.mdec, e.rej);
        end
    endtask

    // Driver: one operation per cycle, expected result queued.
    task automatic op(input string req, input logic [11:0] a, input bit we, input logic [63:0] d);
        exp_t e;
        bit rej;
        @(negedge clk);
        csr_addr  = a;
        csr_we    = we;
        csr_wdata = d;
        rej = 1'b0;
        if (we && a == A_XL) begin
            if (sel_ok(arch_is_64, d[63:60])) model = d;
            else rej = 1'b1;
        end
        e.rdata = (a == A_XL) ? model : 64'h0;
        e.mdec  = dec_of(model[63:60]);
        e.rej   = rej;
        e.req   = req;
        q.push_back(e);
    endtask

    task automatic do_reset(input bit a64);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0; csr_we = 1'b0; csr_addr = A_XL; arch_is_64 = a64;
        repeat (2) @(negedge clk);
        model = '0;
        e.rdata = '0; e.mdec = 2'd0; e.rej = 1'b0; e.req = "R1";
        check("R1", csr_rdata, mode_dec, wr_reject, e);
        rst_n = 1'b1;
    endtask

    // Monitor: pop after each rising edge while inputs are still held.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, csr_rdata, mode_dec, wr_reject, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // 64-bit architecture phase
        do_reset(1'b1);
        op("R6", A_XL, 1, 64'h8123_4567_89AB_CDEF);          // R6 accepted, R8 exact
        op("R3", A_XL, 0, 64'h0);                             // R3 read back layout
        op("R5", A_XL, 1, 64'h1FFF_FFFF_FFFF_FFFF);          // R5 rejected on 64-bit, R10
        op("R7", A_XL, 0, 64'h0);                             // R7 whole word kept
        op("R7", A_XL, 1, 64'h9AAA_BBBB_CCCC_DDDD);          // R7 unknown selector
        op("R7", A_XL, 1, 64'hF000_0000_0000_0001);
        op("R10", A_XL, 0, 64'h0);                            // R10 flag cleared
        op("R2", 12'h181, 1, 64'h0000_1111_2222_3333);       // R2 other address
        op("R2", A_XL, 0, 64'h0);
        op("R2", 12'h100, 0, 64'h0);                          // R2 read elsewhere is 0
        op("R4", A_XL, 1, 64'h0FED_CBA9_8765_4321);          // R4 bare with fields, R9
        op("R8", A_XL, 1, 64'h8000_0000_0000_0000);
        op("R9", A_XL, 0, 64'h0);
        for (int i = 0; i < 16; i++)
            op("R7", A_XL, 1, {i[3:0], 60'h0AB_CDEF_0123_4567});
        // 32-bit architecture phase
        do_reset(1'b0);
        op("R5", A_XL, 1, 64'h1555_6666_7777_8888);          // R5 accepted
        op("R9", A_XL, 0, 64'h0);
        op("R6", A_XL, 1, 64'h8999_AAAA_BBBB_CCCC);          // R6 rejected on 32-bit
        op("R10", A_XL, 1, 64'h8999_AAAA_BBBB_CCCC);         // back-to-back reject
        op("R4", A_XL, 1, 64'h0000_0000_0000_0000);
        op("R2", 12'h180 ^ 12'h001, 1, 64'h1000_0000_0000_0042);
        op("R2", A_XL, 0, 64'h0);
        for (int i = 0; i < 16; i++)
            op("R7", A_XL, 1, {i[3:0], 60'h123_4567_89AB_CDEF});
        op("R8", A_XL, 0, 64'h0);
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R8: %0d results missing, expected 0", q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule